// File: doc/BRIEF.md
# Windowed Framebuffer Write Address Generator

This block sits between a display command decoder and a 5120-byte pixel store. Each byte of the store holds two 4-bit pixels, so the store covers 128 by 80 pixels as 64 byte columns by 80 rows. The decoder programs a rectangular window by giving a first and last byte column and a first and last row. Pixel bytes then arrive on a valid/ready stream. The block turns each accepted byte into one write of the store at address `column + 64 * row`. It then moves its pointer to the next position inside the window, running along a row or down a column as the scan order input selects. At each edge of the window it wraps back to the window start.

The byte stream never stalls: `in_ready` is held high, so every cycle with `in_valid` high transfers one byte, and the block applies no back-pressure. The write port is registered and drives one write in the cycle after the byte is accepted. A redraw flag goes high on any write. The scanout side lowers it with a one-cycle clear strobe.

Top module: `fb_window_addr_gen`

## Requirements
- R1: After reset the column window is 0 to 63, the row window is 0 to 79, both pointers are 0, `mem_we` is 0 and `redraw` is 0.
- R2: `in_ready` is always 1. A byte accepted at a rising edge produces `mem_we` = 1 with `mem_wdata` equal to that byte in the following cycle. A cycle with `in_valid` low produces `mem_we` = 0 in the following cycle.
- R3: `mem_addr` equals column pointer + 64 × row pointer, taken as they stood when the byte was accepted, and always lies below 5120.
- R4: With `vert_mode` = 0 (row-first order), each write advances the column pointer. A column pointer at or beyond the last column returns to the first column instead, and the row pointer then advances, returning to the first row when it is at or beyond the last row.
- R5: With `vert_mode` = 1 (column-first order), each write advances the row pointer. A row pointer at or beyond the last row returns to the first row instead, and the column pointer then advances, returning to the first column when it is at or beyond the last column.
- R6: A window whose first value exceeds its last value makes that axis return to its first value on every advance.
- R7: A strobe on `col_load` or `row_load` stores the window bounds and moves that pointer to the new first value at the same edge. Row bounds of 80 or more are reduced by 80.
- R8: When a load and a write share an edge, the write uses the pointer from before the load, and the loaded first value wins over the advance.
- R9: `redraw` is set in the cycle after any write and cleared in the cycle after `redraw_clr`. If both occur at the same edge, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vert_mode | input | 1 | Scan order: 0 row-first, 1 column-first |
| col_load | input | 1 | Load strobe for the column window |
| col_lo | input | 6 | First byte column of the window |
| col_hi | input | 6 | Last byte column of the window |
| row_load | input | 1 | Load strobe for the row window |
| row_lo | input | 7 | First row of the window |
| row_hi | input | 7 | Last row of the window |
| in_valid | input | 1 | Pixel byte valid |
| in_ready | output | 1 | Pixel byte ready, always 1 |
| in_data | input | 8 | Pixel byte, two 4-bit pixels |
| mem_we | output | 1 | Store write enable |
| mem_addr | output | 13 | Store byte address |
| mem_wdata | output | 8 | Store write data |
| redraw | output | 1 | Frame content changed since last clear |
| redraw_clr | input | 1 | Clear strobe from the scanout side |

## Verification
Every result is due exactly one cycle after its cause: the write enable, address and data follow the accepting rising edge, the redraw flag follows the write or clear edge, and a load shows in the address of the next write. The bench steps a behavioural model at each rising edge from the inputs held there. It compares the outputs with that model at the following falling edge, while the stimulus changes only at falling edges, so each compare sees exactly one edge of effect. The requirement under test tags every address compare, so each windowing rule is reported by name.

// File: rtl/fbw_pkg.sv
package fbw_pkg;
  localparam int FB_COLS = 64;
  localparam int FB_ROWS = 80;

  typedef enum logic {
    ORDER_HORIZ = 1'b0,
    ORDER_VERT  = 1'b1
  } scan_order_e;
endpackage

// File: rtl/fbw_axis.sv
// One window-bounded pointer: holds first/last bounds and the current position.
module fbw_axis #(
  parameter int LIMIT = 64,
  localparam int W = $clog2(LIMIT)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] lo_in,
  input  logic [W-1:0] hi_in,
  input  logic         step,
  output logic [W-1:0] ptr,
  output logic         at_end
);
  localparam logic [W:0]   LIM_X  = (W+1)'(LIMIT);
  localparam logic [W-1:0] LAST_R = W'(LIMIT - 1);

  logic [W-1:0] first_q, last_q, ptr_q;

  function automatic logic [W-1:0] fold(input logic [W-1:0] v);
    logic [W:0] vx;
    vx = {1'b0, v};
    if (vx >= LIM_X) return W'(vx - LIM_X);
    return v;
  endfunction

  assign at_end = (ptr_q >= last_q);
  assign ptr    = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= LAST_R;
      ptr_q   <= '0;
    end else if (load) begin
      first_q <= fold(lo_in);
      last_q  <= fold(hi_in);
      ptr_q   <= fold(lo_in);
    end else if (step) begin
      ptr_q   <= at_end ? first_q : ptr_q + 1'b1;
    end
  end

  p_ptr_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < LIMIT);

  p_wrap_to_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && at_end) |=> (ptr_q == $past(first_q)));

  p_step_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !at_end) |=> (ptr_q == $past(ptr_q) + 1'b1));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(ptr_q));
endmodule

// File: rtl/fbw_addr.sv
// Byte address from column and row pointers.
module fbw_addr #(
  parameter int COLS = 64,
  parameter int ROWS = 80,
  localparam int COL_W  = $clog2(COLS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int ADDR_W = $clog2(COLS * ROWS)
) (
  input  logic [COL_W-1:0]  col,
  input  logic [ROW_W-1:0]  row,
  output logic [ADDR_W-1:0] addr
);
  generate
    if ((COLS & (COLS - 1)) == 0) begin : g_pow2
      assign addr = ADDR_W'({row, col});
    end else begin : g_mult
      assign addr = ADDR_W'(row) * ADDR_W'(COLS) + ADDR_W'(col);
    end
  endgenerate
endmodule

// File: rtl/fb_window_addr_gen.sv
module fb_window_addr_gen
  import fbw_pkg::*;
#(
  parameter int COLS   = FB_COLS,
  parameter int ROWS   = FB_ROWS,
  parameter int DATA_W = 8,
  localparam int COL_W  = $clog2(COLS),
  localparam int ROW_W  = $clog2(ROWS),
  localparam int ADDR_W = $clog2(COLS * ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vert_mode,
  input  logic              col_load,
  input  logic [COL_W-1:0]  col_lo,
  input  logic [COL_W-1:0]  col_hi,
  input  logic              row_load,
  input  logic [ROW_W-1:0]  row_lo,
  input  logic [ROW_W-1:0]  row_hi,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              redraw,
  input  logic              redraw_clr
);
  scan_order_e       order;
  logic              fire;
  logic              col_step, row_step;
  logic              col_end_hit, row_end_hit;
  logic [COL_W-1:0]  col_ptr;
  logic [ROW_W-1:0]  row_ptr;
  logic [ADDR_W-1:0] addr_now;

  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              redraw_q;

  assign in_ready = 1'b1;
  assign fire     = in_valid;
  assign order    = scan_order_e'(vert_mode);

  always_comb begin
    if (order == ORDER_HORIZ) begin
      col_step = fire;
      row_step = fire & col_end_hit;
    end else begin
      row_step = fire;
      col_step = fire & row_end_hit;
    end
  end

  fbw_axis #(.LIMIT(COLS)) u_col (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (col_load),
    .lo_in  (col_lo),
    .hi_in  (col_hi),
    .step   (col_step),
    .ptr    (col_ptr),
    .at_end (col_end_hit)
  );

  fbw_axis #(.LIMIT(ROWS)) u_row (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (row_load),
    .lo_in  (row_lo),
    .hi_in  (row_hi),
    .step   (row_step),
    .ptr    (row_ptr),
    .at_end (row_end_hit)
  );

  fbw_addr #(.COLS(COLS), .ROWS(ROWS)) u_addr (
    .col  (col_ptr),
    .row  (row_ptr),
    .addr (addr_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q     <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      redraw_q <= 1'b0;
    end else begin
      we_q <= fire;
      if (fire) begin
        addr_q <= addr_now;
        data_q <= in_data;
      end
      if (fire)            redraw_q <= 1'b1;
      else if (redraw_clr) redraw_q <= 1'b0;
    end
  end

  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
  assign redraw    = redraw_q;

  p_we_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (mem_we && mem_wdata == $past(in_data)));

  p_no_spurious_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !mem_we);

  p_addr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (int'(mem_addr) < COLS * ROWS));

  p_redraw_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> redraw);

  p_redraw_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (redraw_clr && !in_valid) |=> !redraw);
endmodule

// File: tb/fb_window_addr_gen_tb.sv
`timescale 1ns/1ps
module fb_window_addr_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vert_mode = 1'b0;
  logic       col_load = 1'b0, row_load = 1'b0;
  logic [5:0] col_lo = '0, col_hi = '0;
  logic [6:0] row_lo = '0, row_hi = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       mem_we;
  logic [12:0] mem_addr;
  logic [7:0] mem_wdata;
  logic       redraw;
  logic       redraw_clr = 1'b0;

  always #2.5 clk = ~clk;

  fb_window_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .vert_mode(vert_mode),
    .col_load(col_load), .col_lo(col_lo), .col_hi(col_hi),
    .row_load(row_load), .row_lo(row_lo), .row_hi(row_hi),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .redraw(redraw), .redraw_clr(redraw_clr)
  );

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int m_c, m_r, m_cs, m_ce, m_rs, m_re;
  int e_addr, e_data;
  bit e_we, e_rd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_c = 0; m_r = 0; m_cs = 0; m_ce = 63; m_rs = 0; m_re = 79;
      e_we = 0; e_rd = 0; e_addr = 0; e_data = 0;
    end else begin
      e_we = in_valid;
      if (in_valid) begin
        e_addr = m_c + m_r * 64;
        e_data = int'(in_data);
        e_rd = 1;
        if (!vert_mode) begin
          m_c++;
          if (m_c > m_ce) begin m_c = m_cs; m_r++; end
          if (m_r > m_re) m_r = m_rs;
        end else begin
          m_r++;
          if (m_r > m_re) begin m_r = m_rs; m_c++; end
          if (m_c > m_ce) m_c = m_cs;
        end
      end else if (redraw_clr) begin
        e_rd = 0;
      end
      if (col_load) begin
        m_cs = int'(col_lo); m_ce = int'(col_hi); m_c = m_cs;
      end
      if (row_load) begin
        m_rs = int'(row_lo) % 80; m_re = int'(row_hi) % 80; m_r = m_rs;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "in_ready", int'(in_ready), 1);
      chk("R2", "mem_we", int'(mem_we), int'(e_we));
      if (e_we) begin
        chk(cur_req, "mem_addr", int'(mem_addr), e_addr);
        chk("R2", "mem_wdata", int'(mem_wdata), e_data);
      end
      chk("R9", "redraw", int'(redraw), int'(e_rd));
    end
  end

  task automatic put(input logic [7:0] d);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load_col(input int lo, input int hi);
    col_load = 1'b1; col_lo = 6'(lo); col_hi = 6'(hi);
    @(negedge clk);
    col_load = 1'b0;
  endtask

  task automatic load_row(input int lo, input int hi);
    row_load = 1'b1; row_lo = 7'(lo); row_hi = 7'(hi);
    @(negedge clk);
    row_load = 1'b0;
  endtask

  task automatic run_all();
    // R1: reset state
    @(negedge clk);
    chk("R1", "mem_we in reset", int'(mem_we), 0);
    chk("R1", "redraw in reset", int'(redraw), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "mem_we after reset", int'(mem_we), 0);
    chk("R1", "redraw after reset", int'(redraw), 0);
    cur_req = "R1";
    for (int i = 0; i < 66; i++) put(8'(i));
    // R5: column-first order over the default row window, then a small window
    cur_req = "R5";
    vert_mode = 1'b1;
    for (int i = 0; i < 82; i++) put(8'(i + 3));
    load_col(2, 3);
    load_row(5, 7);
    for (int i = 0; i < 8; i++) put(8'(200 + i));
    // R4: row-first order with wraps on both axes, gaps between bytes
    cur_req = "R4";
    vert_mode = 1'b0;
    load_col(60, 63);
    load_row(78, 79);
    for (int i = 0; i < 10; i++) begin
      put(8'(i * 7));
      if (i % 3 == 0) idle(1);
    end
    // R6: inverted windows
    cur_req = "R6";
    load_col(10, 5);
    for (int i = 0; i < 3; i++) put(8'(i));
    vert_mode = 1'b1;
    load_row(9, 4);
    load_col(0, 1);
    for (int i = 0; i < 4; i++) put(8'(i + 50));
    // R7: row bounds folded into range
    cur_req = "R7";
    vert_mode = 1'b0;
    load_row(100, 120);
    load_col(62, 63);
    for (int i = 0; i < 3; i++) put(8'(i + 90));
    // R8: load at the same edge as a write
    cur_req = "R8";
    in_valid = 1'b1; in_data = 8'hA5; col_load = 1'b1; col_lo = 6'd30; col_hi = 6'd40;
    @(negedge clk);
    col_load = 1'b0; row_load = 1'b1; row_lo = 7'd11; row_hi = 7'd12; in_data = 8'h5A;
    @(negedge clk);
    row_load = 1'b0; in_data = 8'h3C;
    @(negedge clk);
    in_valid = 1'b0;
    // R9: redraw clear and priority
    cur_req = "R9";
    redraw_clr = 1'b1;
    @(negedge clk);
    redraw_clr = 1'b0;
    chk("R9", "redraw cleared", int'(redraw), 0);
    in_valid = 1'b1; redraw_clr = 1'b1; in_data = 8'h77;
    @(negedge clk);
    in_valid = 1'b0; redraw_clr = 1'b0;
    chk("R9", "write beats clear", int'(redraw), 1);
    idle(2);
    chk("R9", "redraw held", int'(redraw), 1);
    // R3: mixed random traffic
    cur_req = "R3";
    for (int i = 0; i < 400; i++) begin
      in_valid   = ($urandom_range(0, 3) != 0);
      in_data    = 8'($urandom);
      vert_mode  = ($urandom_range(0, 15) == 0) ? ~vert_mode : vert_mode;
      redraw_clr = ($urandom_range(0, 7) == 0);
      col_load   = ($urandom_range(0, 40) == 0);
      row_load   = ($urandom_range(0, 40) == 0);
      col_lo = 6'($urandom); col_hi = 6'($urandom);
      row_lo = 7'($urandom); row_hi = 7'($urandom);
      @(negedge clk);
    end
    in_valid = 1'b0; col_load = 1'b0; row_load = 1'b0; redraw_clr = 1'b0;
    idle(3);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule